// File: doc/BRIEF.md
# Banked Dual-Read Dword Array

The block is a storage array built from eight independent banks, each one dword (32 bits) wide. Consecutive dwords of a 32-byte line are spread across the eight banks, so one line puts one dword in each bank. The bank for a byte address is selected by address bits 4:2, and the line index comes from the bits above bit 4. The array always hits. Its depth in lines is a parameter.

Two read ports, U and V, can each present a request every cycle. Each request can be for a whole dword or for a single byte. When the two requests map to different banks, both are accepted in the same cycle. When they map to the same bank, U is accepted and V sees its stall output high, so the requester holds V for another cycle. The stall decision looks only at the bank index, so two reads of the same dword still collide. A single write port stores whole dwords and has priority over any read that targets the same bank in that cycle.

Accepted reads return their data, with a per-port valid, on the cycle after acceptance. A port that stays stalled returns nothing for that cycle.

Top module: `bankdual_rd_array`

## Requirements
- R1: A dword written at dword index W sits in bank W[2:0] and line W[top:3]. A read at byte address A uses bank A[4:2] and line A[top:5]. Every written dword is read back unchanged.
- R2: A read accepted in a cycle (req high, stall low) raises that port's rvalid in the next cycle, carrying the data.
- R3: When U and V request different banks and no write hits either bank, neither port stalls and both return data in the next cycle.
- R4: When U and V request the same bank, U is accepted and v_stall is high. If V holds its request into the next cycle and there is no new conflict, V is accepted then, so its data arrives two cycles after it was first presented.
- R5: A collision depends on the bank index alone. U and V reading the very same dword still stall V for one cycle.
- R6: When the byte select input is 1, a read returns the byte chosen by address bits 1:0 (0 is the lowest byte) in bits 7:0, with bits 31:8 zero. Two byte reads at consecutive addresses inside one dword collide.
- R7: When the byte select input is 0, a read returns the full dword, and address bits 1:0 have no effect.
- R8: A write to a bank stalls any U or V read of that bank in the same cycle. Reads of other banks in that cycle are unaffected.
- R9: A write stores its data at the clock edge. A read accepted in the following cycle returns the new value.
- R10: After reset both rvalid outputs are low. A stall output is high only while its port's req is high.
- R11: A port raises rvalid only on the cycle after an accepted read. A stalled or idle cycle produces no rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W-2 | Dword index of the write |
| wr_data | input | 32 | Write data |
| u_req | input | 1 | U read request, held while u_stall is high |
| u_addr | input | ADDR_W | U byte address |
| u_byte | input | 1 | U byte-mode select (1 = byte, 0 = dword) |
| u_stall | output | 1 | U request not accepted this cycle |
| u_rvalid | output | 1 | U read data valid |
| u_rdata | output | 32 | U read data |
| v_req | input | 1 | V read request, held while v_stall is high |
| v_addr | input | ADDR_W | V byte address |
| v_byte | input | 1 | V byte-mode select (1 = byte, 0 = dword) |
| v_stall | output | 1 | V request not accepted this cycle |
| v_rvalid | output | 1 | V read data valid |
| v_rdata | output | 32 | V read data |

## Verification
The stall outputs are combinational from the current requests, so the bench reads them shortly after driving its inputs, before the clock edge that would accept the request. Read data is due exactly one edge after acceptance. The driver records each accepted read in a per-port queue and sets a due flag for that edge. The monitor samples one nanosecond after every rising edge, checks that rvalid matches the due flag, and compares the data against the popped item. A stalled V or U request therefore shows up as a missing rvalid in that cycle and as one delayed one cycle later, which the monitor checks by timing as well as by data.

// File: rtl/bankarr_pkg.sv
package bankarr_pkg;
  localparam int NBANKS = 8;
  localparam int BANK_W = $clog2(NBANKS);
  localparam int DW     = 32;
  localparam int OFF_W  = 2;

  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [DW-1:0]     word_t;

  // Pick the read lane: a whole dword, or one byte zero-extended.
  function automatic word_t lane_fmt(word_t w, off_t off, logic byte_mode);
    word_t r;
    if (!byte_mode) begin
      r = w;
    end else begin
      case (off)
        2'd0:    r = {24'd0, w[7:0]};
        2'd1:    r = {24'd0, w[15:8]};
        2'd2:    r = {24'd0, w[23:16]};
        default: r = {24'd0, w[31:24]};
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/bank_arb.sv
module bank_arb
  import bankarr_pkg::*;
#(
  parameter int LINE_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  bank_t                        wr_bank,
  input  logic [LINE_W-1:0]            wr_line,
  input  logic                         u_req,
  input  bank_t                        u_bank,
  input  logic [LINE_W-1:0]            u_line,
  input  logic                         v_req,
  input  bank_t                        v_bank,
  input  logic [LINE_W-1:0]            v_line,
  output logic                         u_stall,
  output logic                         v_stall,
  output logic                         u_acc,
  output logic                         v_acc,
  output logic [NBANKS-1:0]            bank_we,
  output logic [NBANKS-1:0]            bank_re,
  output logic [NBANKS-1:0][LINE_W-1:0] bank_idx
);
  logic wr_hits_u, wr_hits_v, uv_same;

  always_comb begin
    wr_hits_u = wr_en && (wr_bank == u_bank);
    wr_hits_v = wr_en && (wr_bank == v_bank);
    uv_same   = u_req && (u_bank == v_bank);
    u_stall   = u_req && wr_hits_u;
    v_stall   = v_req && (wr_hits_v || uv_same);
    u_acc     = u_req && !u_stall;
    v_acc     = v_req && !v_stall;
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank_sel
    logic take_w, take_u, take_v;
    always_comb begin
      take_w      = wr_en && (wr_bank == bank_t'(b));
      take_u      = u_acc && (u_bank == bank_t'(b));
      take_v      = v_acc && (v_bank == bank_t'(b));
      bank_we[b]  = take_w;
      bank_re[b]  = take_u || take_v;
      if (take_w)      bank_idx[b] = wr_line;
      else if (take_u) bank_idx[b] = u_line;
      else             bank_idx[b] = v_line;
    end
  end

  // R4
  same_bank_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u_req && v_req && (u_bank == v_bank)) |-> (v_stall && !v_acc));
  // R8
  wr_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && u_req && (wr_bank == u_bank)) |-> (u_stall && !u_acc));
  // R3
  split_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u_req && v_req && (u_bank != v_bank) && !wr_en) |-> (u_acc && v_acc));
  // R10
  stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!u_req |-> !u_stall) and (!v_req |-> !v_stall));
endmodule

// File: rtl/dword_bank.sv
module dword_bank
  import bankarr_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             re,
  input  logic [IDX_W-1:0] idx,
  input  word_t            wdata,
  output word_t            rdata
);
  word_t mem [DEPTH];
  word_t rdata_q, rdata_d;

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (re) rdata_d = mem[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R8
  one_op_per_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re));
endmodule

// File: rtl/rd_port.sv
module rd_port
  import bankarr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc,
  input  bank_t                  bank,
  input  off_t                   off,
  input  logic                   byte_mode,
  input  logic [NBANKS-1:0][DW-1:0] bank_rdata,
  output logic                   rvalid,
  output word_t                  rdata
);
  logic  valid_q, valid_d;
  bank_t bank_q, bank_d;
  off_t  off_q, off_d;
  logic  byte_q, byte_d;

  always_comb begin
    valid_d = acc;
    bank_d  = bank_q;
    off_d   = off_q;
    byte_d  = byte_q;
    if (acc) begin
      bank_d = bank;
      off_d  = off;
      byte_d = byte_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      bank_q  <= '0;
      off_q   <= '0;
      byte_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (acc) begin
        bank_q <= bank_d;
        off_q  <= off_d;
        byte_q <= byte_d;
      end
    end
  end

  assign rvalid = valid_q;
  assign rdata  = lane_fmt(bank_rdata[bank_q], off_q, byte_q);

  // R2
  accept_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rvalid);
  // R11
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rvalid);
endmodule

// File: rtl/bankdual_rd_array.sv
module bankdual_rd_array
  import bankarr_pkg::*;
#(
  parameter int LINES = 32,
  localparam int LINE_W = $clog2(LINES),
  localparam int ADDR_W = LINE_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-3:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              u_req,
  input  logic [ADDR_W-1:0] u_addr,
  input  logic              u_byte,
  output logic              u_stall,
  output logic              u_rvalid,
  output logic [31:0]       u_rdata,
  input  logic              v_req,
  input  logic [ADDR_W-1:0] v_addr,
  input  logic              v_byte,
  output logic              v_stall,
  output logic              v_rvalid,
  output logic [31:0]       v_rdata
);
  bank_t             wr_bank, u_bank, v_bank;
  logic [LINE_W-1:0] wr_line, u_line, v_line;
  off_t              u_off, v_off;
  logic              u_acc, v_acc;
  logic [NBANKS-1:0] bank_we, bank_re;
  logic [NBANKS-1:0][LINE_W-1:0] bank_idx;
  logic [NBANKS-1:0][DW-1:0]     bank_rdata;

  always_comb begin
    wr_bank = wr_addr[BANK_W-1:0];
    wr_line = wr_addr[ADDR_W-3:BANK_W];
    u_off   = u_addr[1:0];
    u_bank  = u_addr[4:2];
    u_line  = u_addr[ADDR_W-1:5];
    v_off   = v_addr[1:0];
    v_bank  = v_addr[4:2];
    v_line  = v_addr[ADDR_W-1:5];
  end

  bank_arb #(.LINE_W(LINE_W)) arb_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_line(wr_line),
    .u_req(u_req), .u_bank(u_bank), .u_line(u_line),
    .v_req(v_req), .v_bank(v_bank), .v_line(v_line),
    .u_stall(u_stall), .v_stall(v_stall),
    .u_acc(u_acc), .v_acc(v_acc),
    .bank_we(bank_we), .bank_re(bank_re), .bank_idx(bank_idx)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_banks
    dword_bank #(.DEPTH(LINES)) bank_i (
      .clk(clk), .rst_n(rst_n),
      .we(bank_we[b]), .re(bank_re[b]), .idx(bank_idx[b]),
      .wdata(wr_data), .rdata(bank_rdata[b])
    );
  end

  rd_port u_port_i (
    .clk(clk), .rst_n(rst_n), .acc(u_acc), .bank(u_bank), .off(u_off),
    .byte_mode(u_byte), .bank_rdata(bank_rdata),
    .rvalid(u_rvalid), .rdata(u_rdata)
  );

  rd_port v_port_i (
    .clk(clk), .rst_n(rst_n), .acc(v_acc), .bank(v_bank), .off(v_off),
    .byte_mode(v_byte), .bank_rdata(bank_rdata),
    .rvalid(v_rvalid), .rdata(v_rdata)
  );

  // R6
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u_acc && u_byte) |=> (u_rdata[31:8] == 24'd0));
endmodule

// File: tb/bankdual_rd_array_tb_top.sv
`timescale 1ns/1ps
module bankdual_rd_array_tb_top;
  localparam int LINES  = 32;
  localparam int ADDR_W = $clog2(LINES) + 5;
  localparam int NW     = LINES * 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-3:0] wr_addr;
  logic [31:0]       wr_data;
  logic              u_req, u_byte, v_req, v_byte;
  logic [ADDR_W-1:0] u_addr, v_addr;
  logic              u_stall, u_rvalid, v_stall, v_rvalid;
  logic [31:0]       u_rdata, v_rdata;

  always #2.5 clk = ~clk;

  bankdual_rd_array #(.LINES(LINES)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .u_req(u_req), .u_addr(u_addr), .u_byte(u_byte),
    .u_stall(u_stall), .u_rvalid(u_rvalid), .u_rdata(u_rdata),
    .v_req(v_req), .v_addr(v_addr), .v_byte(v_byte),
    .v_stall(v_stall), .v_rvalid(v_rvalid), .v_rdata(v_rdata)
  );

  typedef struct { logic [31:0] d; string tag; } item_t;
  item_t uq[$];
  item_t vq[$];
  logic [31:0] model [NW];
  int  checks = 0;
  int  errors = 0;
  bit  u_due = 0, v_due = 0, running = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [ADDR_W-1:0] a, input bit bm);
    logic [31:0] w;
    w = model[a >> 2];
    if (bm) return (w >> (8 * a[1:0])) & 32'hFF;
    return w;
  endfunction

  // Drive one cycle, check stalls, record accepted reads.
  task automatic step(input bit we, input int wa, input logic [31:0] wd,
                      input bit ur, input int ua, input bit ub,
                      input bit vr, input int va, input bit vb,
                      input string tag);
    bit exp_us, exp_vs;
    item_t it;
    @(negedge clk);
    wr_en = we; wr_addr = wa[ADDR_W-3:0]; wr_data = wd;
    u_req = ur; u_addr = ua[ADDR_W-1:0]; u_byte = ub;
    v_req = vr; v_addr = va[ADDR_W-1:0]; v_byte = vb;
    #1;
    exp_us = ur && we && (wa[2:0] == ua[4:2]);
    exp_vs = vr && ((we && (wa[2:0] == va[4:2])) || (ur && (ua[4:2] == va[4:2])));
    chk(u_stall == exp_us, {tag, " u_stall"}, 32'(u_stall), 32'(exp_us));
    chk(v_stall == exp_vs, {tag, " v_stall"}, 32'(v_stall), 32'(exp_vs));
    if (ur && !exp_us) begin
      it.d = exp_rd(ua[ADDR_W-1:0], ub); it.tag = tag; uq.push_back(it); u_due = 1;
    end
    if (vr && !exp_vs) begin
      it.d = exp_rd(va[ADDR_W-1:0], vb); it.tag = tag; vq.push_back(it); v_due = 1;
    end
    @(posedge clk);
    if (we) model[wa] = wd;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  // Monitor: one edge after acceptance the data is due (R2, R11).
  always @(posedge clk) begin
    #1;
    if (running) begin
      item_t it;
      chk(u_rvalid == u_due, "R2/R11 u_rvalid timing", 32'(u_rvalid), 32'(u_due));
      if (u_rvalid && uq.size() > 0) begin
        it = uq.pop_front();
        chk(u_rdata == it.d, {it.tag, " u_rdata"}, u_rdata, it.d);
      end
      chk(v_rvalid == v_due, "R2/R11 v_rvalid timing", 32'(v_rvalid), 32'(v_due));
      if (v_rvalid && vq.size() > 0) begin
        it = vq.pop_front();
        chk(v_rdata == it.d, {it.tag, " v_rdata"}, v_rdata, it.d);
      end
      u_due = 0;
      v_due = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 0; wr_addr = '0; wr_data = '0;
    u_req = 0; u_addr = '0; u_byte = 0;
    v_req = 0; v_addr = '0; v_byte = 0;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(!u_rvalid && !v_rvalid, "R10 rvalid after reset", 32'({u_rvalid, v_rvalid}), 32'd0);
    chk(!u_stall && !v_stall, "R10 stall without req", 32'({u_stall, v_stall}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    running = 1;

    // R1 R9: fill every dword
    for (int i = 0; i < NW; i++)
      step(1, i, {i[7:0] ^ 8'hA5, i[7:0], 8'h3C, ~i[7:0]}, 0, 0, 0, 0, 0, 0, "R9 fill");
    // R1 R3 R7: paired reads of adjacent dwords, low bits set on U
    for (int i = 0; i < NW; i += 2)
      step(0, 0, 0, 1, i * 4 + (i % 4), 0, 1, (i + 1) * 4, 0, "R1 R3 R7 readback");
    idle();

    // R4: same bank, different lines; V held then accepted
    step(0, 0, 0, 1, 'h040, 0, 1, 'h060, 0, "R4 collide");
    step(0, 0, 0, 1, 'h044, 0, 1, 'h060, 0, "R4 held V");
    idle();
    // R4: V held while U goes idle
    step(0, 0, 0, 1, 'h0A8, 0, 1, 'h1E8, 0, "R4 collide2");
    step(0, 0, 0, 0, 0, 0, 1, 'h1E8, 0, "R4 held V alone");
    idle();

    // R5: same dword on both ports
    step(0, 0, 0, 1, 'h084, 0, 1, 'h084, 0, "R5 same dword");
    step(0, 0, 0, 0, 0, 0, 1, 'h084, 0, "R5 held V");
    idle();

    // R6: byte reads, all offsets, consecutive bytes collide
    step(0, 0, 0, 1, 'h104, 1, 1, 'h109, 1, "R6 byte lanes");
    step(0, 0, 0, 1, 'h106, 1, 1, 'h10B, 1, "R6 byte lanes");
    step(0, 0, 0, 1, 'h105, 1, 1, 'h106, 1, "R6 consecutive collide");
    step(0, 0, 0, 1, 'h107, 1, 1, 'h106, 1, "R6 consecutive collide");
    step(0, 0, 0, 0, 0, 0, 1, 'h106, 1, "R6 held V");
    idle();

    // R7: dword read with offset 3
    step(0, 0, 0, 1, 'h133, 0, 1, 'h2F1, 0, "R7 dword ignores low bits");
    idle();

    // R8 R9: write blocks both ports on its bank, other bank unaffected
    step(1, 'h22, 32'hDEADBEEF, 1, 'h088, 0, 1, 'h08C, 0, "R8 write blocks U");
    step(1, 'h42, 32'h12345678, 1, 'h088, 0, 1, 'h108, 0, "R8 write blocks V");
    step(0, 0, 0, 1, 'h088, 0, 1, 'h108, 0, "R9 read after write");
    step(1, 'h07, 32'hCAFEF00D, 1, 'h01C, 1, 1, 'h01D, 1, "R8 write blocks both");
    step(0, 0, 0, 1, 'h01F, 1, 0, 0, 0, "R9 new byte");
    idle();
    idle();

    chk(uq.size() == 0, "R11 u queue drained", uq.size(), 0);
    chk(vq.size() == 0, "R11 v queue drained", vq.size(), 0);
    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule